// File: doc/BRIEF.md
# Tagged Memory Command Request Port

This block sits on the requesting side of an external-memory path. Local logic hands it write commands (address and data) and read commands (address only). The block gives each command a tag from a per-direction wrapping counter and parks the command in one of two independent queues. A memory controller drains the queues. Each queue offers its oldest command with a request line, and the controller takes it by pulsing an acknowledge. Each queue also reports how many commands are waiting and raises a flag when only one is left.

Completion comes back by tag, not by position. When the controller finishes a write, it strobes a done flag together with that write's tag. Read data arrives with a valid strobe and the read's tag. The block forwards both completion streams to local logic one cycle later, in the order they arrive, and never reorders them. The block counts read tags that have been issued but not yet returned. It stops accepting new reads while every tag value is in flight, so no two outstanding reads can share a tag.

Top module: `memreq_port`

## Requirements
- R1: A write command presented with `wr_cmd_valid` while `wr_cmd_ready` is high is queued with its address, data and tag. Queued commands reach the controller side in acceptance order. The same holds for reads through `rd_cmd_valid` and `rd_cmd_ready`.
- R2: Tags come from two separate counters, one for writes and one for reads. Both are zero after reset. `wr_next_tag` and `rd_next_tag` show the tag the next accepted command receives. Each counter advances by one per accepted command and wraps modulo 2^width.
- R3: A queue's request output is high whenever the queue holds a command. While the request is high and not acknowledged, the offered address, data and tag hold steady. A command pushed into an empty queue is offered one cycle after the push. After an acknowledge, the next queued command is offered from the very next clock edge.
- R4: `mc_wr_count` and `mc_rd_count` give the number of commands waiting in each queue. `mc_wr_aempty` and `mc_rd_aempty` are high exactly when that count is 1.
- R5: A full queue deasserts its ready output. A command offered while full is ignored: the count stays at the depth, the tag counter does not advance, and the dropped command never reaches the controller or memory.
- R6: A write completion (`mc_wr_done_valid` with `mc_wr_done_tag`) appears on `wr_done_valid` and `wr_done_tag` one cycle later.
- R7: The number of read tags in flight rises by one per accepted read and falls by one per read return. `rd_cmd_ready` is low while 2^RTAG_W reads are in flight, and a read return frees room again.
- R8: Each read return (`mc_rd_data_valid` with data and tag) appears one cycle later on `rd_resp_valid`, `rd_resp_data` and `rd_resp_tag`, in arrival order, including when tags arrive out of issue order. `rd_resp_valid` is never raised without a return.
- R9: The write and read paths are independent. Both can accept, issue and complete in the same cycle without affecting each other.
- R10: During and right after reset, both requests are low, both counts are 0, both almost-empty flags are low, both ready outputs are high, both next tags are 0 and both forwarded valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd_valid | input | 1 | Local write command offered |
| wr_cmd_addr | input | ADDR_W | Write address |
| wr_cmd_data | input | DATA_W | Write data |
| wr_cmd_ready | output | 1 | Write queue can accept |
| wr_next_tag | output | WTAG_W | Tag the next accepted write receives |
| rd_cmd_valid | input | 1 | Local read command offered |
| rd_cmd_addr | input | ADDR_W | Read address |
| rd_cmd_ready | output | 1 | Read queue can accept and a tag is free |
| rd_next_tag | output | RTAG_W | Tag the next accepted read receives |
| mc_wr_req | output | 1 | Write command offered to controller |
| mc_wr_ack | input | 1 | Controller takes the offered write |
| mc_wr_addr | output | ADDR_W | Offered write address |
| mc_wr_data | output | DATA_W | Offered write data |
| mc_wr_tag | output | WTAG_W | Offered write tag |
| mc_wr_count | output | clog2(WQ_DEPTH+1) | Writes waiting |
| mc_wr_aempty | output | 1 | Exactly one write waiting |
| mc_rd_req | output | 1 | Read command offered to controller |
| mc_rd_ack | input | 1 | Controller takes the offered read |
| mc_rd_addr | output | ADDR_W | Offered read address |
| mc_rd_tag | output | RTAG_W | Offered read tag |
| mc_rd_count | output | clog2(RQ_DEPTH+1) | Reads waiting |
| mc_rd_aempty | output | 1 | Exactly one read waiting |
| mc_wr_done_valid | input | 1 | Controller reports a finished write |
| mc_wr_done_tag | input | WTAG_W | Tag of the finished write |
| mc_rd_data_valid | input | 1 | Controller returns read data |
| mc_rd_data | input | DATA_W | Returned read data |
| mc_rd_data_tag | input | RTAG_W | Tag of the returned read |
| wr_done_valid | output | 1 | Forwarded write completion |
| wr_done_tag | output | WTAG_W | Forwarded write tag |
| rd_resp_valid | output | 1 | Forwarded read return |
| rd_resp_data | output | DATA_W | Forwarded read data |
| rd_resp_tag | output | RTAG_W | Forwarded read tag |

## Verification
The hardest state to reach is the read tag limit. Getting there needs every one of the 2^RTAG_W tag values in flight at once, with the controller still taking commands but holding back all returns. The bench gets there by letting its controller model acknowledge every read while dropping the data. It then offers reads every cycle until ready falls, and counts acceptances against 256. Next it injects hand-made returns with tags out of issue order. This shows that room reopens and that completions pass through without reordering.

// File: rtl/memreq_pkg.sv
package memreq_pkg;

  // bits needed to hold values 0..depth
  function automatic int unsigned count_width(int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  // bits needed to address depth entries (at least one)
  function automatic int unsigned index_width(int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

  // number of distinct tags of a given width
  function automatic int unsigned tag_space(int unsigned w);
    return 1 << w;
  endfunction

  // circular index increment
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
    return (v == lim - 1) ? 0 : v + 1;
  endfunction

  // almost-empty rule: a single entry remains
  function automatic bit last_one(int unsigned occ);
    return occ == 1;
  endfunction

endpackage

// File: rtl/cmd_fifo.sv
module cmd_fifo
  import memreq_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = count_width(DEPTH),
  localparam int unsigned PW   = index_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [W-1:0]  push_data,
  output logic          push_ready,
  input  logic          pop,
  output logic          head_valid,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] count,
  output logic          aempty,
  output logic          push_fire,
  output logic          pop_fire
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] occ;

  assign push_ready = (occ != FULL);
  assign head_valid = (occ != '0);
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop && head_valid;
  assign head_data  = store[rptr];
  assign count      = occ;
  assign aempty     = last_one(occ);

  always_ff @(posedge clk) begin
    if (push_fire) store[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push_fire) wptr <= PW'(wrap_inc(wptr, DEPTH));
      if (pop_fire)  rptr <= PW'(wrap_inc(rptr, DEPTH));
      case ({push_fire, pop_fire})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

endmodule

// File: rtl/tag_alloc.sv
module tag_alloc
  import memreq_pkg::*;
#(
  parameter int unsigned TW    = 8,
  parameter bit          LIMIT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give_back,
  output logic          room,
  output logic [TW-1:0] next_tag,
  output logic [TW:0]   inflight
);

  always_ff @(posedge clk) begin
    if (!rst_n)    next_tag <= '0;
    else if (take) next_tag <= next_tag + 1'b1;
  end

  generate
    if (LIMIT) begin : g_limited
      localparam logic [TW:0] SPACE = (TW + 1)'(tag_space(TW));
      logic [TW:0] busy;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          busy <= '0;
        end else begin
          case ({take, give_back})
            2'b10:   busy <= busy + 1'b1;
            2'b01:   busy <= (busy != '0) ? busy - 1'b1 : busy;
            default: busy <= busy;
          endcase
        end
      end

      assign room     = (busy != SPACE);
      assign inflight = busy;
    end else begin : g_free
      logic unused_give_back;
      assign unused_give_back = give_back;
      assign room     = 1'b1;
      assign inflight = '0;
    end
  endgenerate

endmodule

// File: rtl/resp_fwd.sv
module resp_fwd #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/memreq_port.sv
module memreq_port
  import memreq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WTAG_W   = 4,
  parameter int unsigned RTAG_W   = 8,
  parameter int unsigned WQ_DEPTH = 8,
  parameter int unsigned RQ_DEPTH = 8,
  localparam int unsigned WCW     = count_width(WQ_DEPTH),
  localparam int unsigned RCW     = count_width(RQ_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd_valid,
  input  logic [ADDR_W-1:0] wr_cmd_addr,
  input  logic [DATA_W-1:0] wr_cmd_data,
  output logic              wr_cmd_ready,
  output logic [WTAG_W-1:0] wr_next_tag,
  input  logic              rd_cmd_valid,
  input  logic [ADDR_W-1:0] rd_cmd_addr,
  output logic              rd_cmd_ready,
  output logic [RTAG_W-1:0] rd_next_tag,
  output logic              mc_wr_req,
  input  logic              mc_wr_ack,
  output logic [ADDR_W-1:0] mc_wr_addr,
  output logic [DATA_W-1:0] mc_wr_data,
  output logic [WTAG_W-1:0] mc_wr_tag,
  output logic [WCW-1:0]    mc_wr_count,
  output logic              mc_wr_aempty,
  output logic              mc_rd_req,
  input  logic              mc_rd_ack,
  output logic [ADDR_W-1:0] mc_rd_addr,
  output logic [RTAG_W-1:0] mc_rd_tag,
  output logic [RCW-1:0]    mc_rd_count,
  output logic              mc_rd_aempty,
  input  logic              mc_wr_done_valid,
  input  logic [WTAG_W-1:0] mc_wr_done_tag,
  input  logic              mc_rd_data_valid,
  input  logic [DATA_W-1:0] mc_rd_data,
  input  logic [RTAG_W-1:0] mc_rd_data_tag,
  output logic              wr_done_valid,
  output logic [WTAG_W-1:0] wr_done_tag,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_resp_data,
  output logic [RTAG_W-1:0] rd_resp_tag
);

  localparam int unsigned WCMD_W = WTAG_W + ADDR_W + DATA_W;
  localparam int unsigned RCMD_W = RTAG_W + ADDR_W;
  localparam int unsigned RRSP_W = RTAG_W + DATA_W;

  // named internal events, observed by the bound checker
  logic              wr_push_fire, wr_pop_fire;
  logic              rd_push_fire, rd_pop_fire;
  logic [RTAG_W:0]   rd_inflight;
  logic [WTAG_W:0]   wr_inflight_unused;
  logic              rd_room, wr_room_unused;
  logic              rd_fifo_ready;
  logic [WCMD_W-1:0] wr_head;
  logic [RCMD_W-1:0] rd_head;
  logic [RRSP_W-1:0] rd_fwd_q;

  // write path
  tag_alloc #(.TW(WTAG_W), .LIMIT(1'b0)) wtag_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (wr_push_fire),
    .give_back (mc_wr_done_valid),
    .room      (wr_room_unused),
    .next_tag  (wr_next_tag),
    .inflight  (wr_inflight_unused)
  );

  cmd_fifo #(.W(WCMD_W), .DEPTH(WQ_DEPTH)) wq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (wr_cmd_valid),
    .push_data  ({wr_next_tag, wr_cmd_addr, wr_cmd_data}),
    .push_ready (wr_cmd_ready),
    .pop        (mc_wr_ack),
    .head_valid (mc_wr_req),
    .head_data  (wr_head),
    .count      (mc_wr_count),
    .aempty     (mc_wr_aempty),
    .push_fire  (wr_push_fire),
    .pop_fire   (wr_pop_fire)
  );

  assign {mc_wr_tag, mc_wr_addr, mc_wr_data} = wr_head;

  resp_fwd #(.W(WTAG_W)) wdone_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (mc_wr_done_valid),
    .in_data   (mc_wr_done_tag),
    .out_valid (wr_done_valid),
    .out_data  (wr_done_tag)
  );

  // read path
  tag_alloc #(.TW(RTAG_W), .LIMIT(1'b1)) rtag_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (rd_push_fire),
    .give_back (mc_rd_data_valid),
    .room      (rd_room),
    .next_tag  (rd_next_tag),
    .inflight  (rd_inflight)
  );

  cmd_fifo #(.W(RCMD_W), .DEPTH(RQ_DEPTH)) rq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (rd_cmd_valid && rd_room),
    .push_data  ({rd_next_tag, rd_cmd_addr}),
    .push_ready (rd_fifo_ready),
    .pop        (mc_rd_ack),
    .head_valid (mc_rd_req),
    .head_data  (rd_head),
    .count      (mc_rd_count),
    .aempty     (mc_rd_aempty),
    .push_fire  (rd_push_fire),
    .pop_fire   (rd_pop_fire)
  );

  assign rd_cmd_ready = rd_fifo_ready && rd_room;
  assign {mc_rd_tag, mc_rd_addr} = rd_head;

  resp_fwd #(.W(RRSP_W)) rresp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (mc_rd_data_valid),
    .in_data   ({mc_rd_data_tag, mc_rd_data}),
    .out_valid (rd_resp_valid),
    .out_data  (rd_fwd_q)
  );

  assign {rd_resp_tag, rd_resp_data} = rd_fwd_q;

endmodule

// File: rtl/memreq_port_chk.sv
module memreq_port_chk
  import memreq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WTAG_W   = 4,
  parameter int unsigned RTAG_W   = 8,
  parameter int unsigned WQ_DEPTH = 8,
  parameter int unsigned RQ_DEPTH = 8,
  localparam int unsigned WCW     = count_width(WQ_DEPTH),
  localparam int unsigned RCW     = count_width(RQ_DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mc_wr_req,
  input logic              mc_wr_ack,
  input logic [ADDR_W-1:0] mc_wr_addr,
  input logic [DATA_W-1:0] mc_wr_data,
  input logic [WTAG_W-1:0] mc_wr_tag,
  input logic [WCW-1:0]    mc_wr_count,
  input logic              mc_wr_aempty,
  input logic              mc_rd_req,
  input logic              mc_rd_ack,
  input logic [RTAG_W-1:0] mc_rd_tag,
  input logic [RCW-1:0]    mc_rd_count,
  input logic              wr_push_fire,
  input logic              wr_pop_fire,
  input logic              rd_push_fire,
  input logic              rd_pop_fire,
  input logic [RTAG_W:0]   rd_inflight,
  input logic [WTAG_W-1:0] wr_next_tag,
  input logic              mc_wr_done_valid,
  input logic [WTAG_W-1:0] mc_wr_done_tag,
  input logic              wr_done_valid,
  input logic [WTAG_W-1:0] wr_done_tag,
  input logic              mc_rd_data_valid,
  input logic [RTAG_W-1:0] mc_rd_data_tag,
  input logic [DATA_W-1:0] mc_rd_data,
  input logic              rd_resp_valid,
  input logic [RTAG_W-1:0] rd_resp_tag,
  input logic [DATA_W-1:0] rd_resp_data
);

  localparam logic [WCW-1:0]  WFULL  = WCW'(WQ_DEPTH);
  localparam logic [RCW-1:0]  RFULL  = RCW'(RQ_DEPTH);
  localparam logic [RTAG_W:0] RSPACE = (RTAG_W + 1)'(tag_space(RTAG_W));

  p_wr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mc_wr_count <= WFULL);

  p_rd_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mc_rd_count <= RFULL);

  p_full_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_wr_count == WFULL && !wr_pop_fire) |=> mc_wr_count == WFULL);

  p_head_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_wr_req && !mc_wr_ack) |=>
      (mc_wr_req && $stable(mc_wr_tag) && $stable(mc_wr_addr) && $stable(mc_wr_data)));

  p_next_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_rd_req && mc_rd_ack && mc_rd_count > RCW'(1)) |=>
      (mc_rd_req && mc_rd_tag == $past(mc_rd_tag) + RTAG_W'(1)));

  p_wr_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pop_fire && !wr_push_fire) |=> mc_wr_count == $past(mc_wr_count) - WCW'(1));

  p_rd_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop_fire && !rd_push_fire) |=> mc_rd_count == $past(mc_rd_count) - RCW'(1));

  p_aempty_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_wr_aempty && mc_wr_ack && !wr_push_fire) |=> !mc_wr_req);

  p_wtag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_push_fire |=> wr_next_tag == $past(wr_next_tag) + WTAG_W'(1));

  p_rd_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_push_fire |-> rd_inflight < RSPACE);

  p_wdone_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mc_wr_done_valid |=> (wr_done_valid && wr_done_tag == $past(mc_wr_done_tag)));

  p_rd_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mc_rd_data_valid |=>
      (rd_resp_valid && rd_resp_tag == $past(mc_rd_data_tag) &&
       rd_resp_data == $past(mc_rd_data)));

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_rd_data_valid |=> !rd_resp_valid);

endmodule

bind memreq_port memreq_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WTAG_W(WTAG_W), .RTAG_W(RTAG_W),
  .WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH)
) chk_i (.*);

// File: tb/memreq_port_tb_top.sv
module memreq_port_tb_top;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int WT = 4;
  localparam int RT = 8;
  localparam int QD = 4;
  localparam int CWD = $clog2(QD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          wr_cmd_valid = 0, rd_cmd_valid = 0;
  logic [AW-1:0] wr_cmd_addr = 0, rd_cmd_addr = 0;
  logic [DW-1:0] wr_cmd_data = 0;
  logic          wr_cmd_ready, rd_cmd_ready;
  logic [WT-1:0] wr_next_tag;
  logic [RT-1:0] rd_next_tag;
  logic          mc_wr_req, mc_rd_req;
  logic          mc_wr_ack = 0, mc_rd_ack = 0;
  logic [AW-1:0] mc_wr_addr, mc_rd_addr;
  logic [DW-1:0] mc_wr_data;
  logic [WT-1:0] mc_wr_tag;
  logic [RT-1:0] mc_rd_tag;
  logic [CWD-1:0] mc_wr_count, mc_rd_count;
  logic          mc_wr_aempty, mc_rd_aempty;
  logic          mc_wr_done_valid = 0;
  logic [WT-1:0] mc_wr_done_tag = 0;
  logic          mc_rd_data_valid = 0;
  logic [DW-1:0] mc_rd_data = 0;
  logic [RT-1:0] mc_rd_data_tag = 0;
  logic          wr_done_valid, rd_resp_valid;
  logic [WT-1:0] wr_done_tag;
  logic [DW-1:0] rd_resp_data;
  logic [RT-1:0] rd_resp_tag;

  memreq_port #(.ADDR_W(AW), .DATA_W(DW), .WTAG_W(WT), .RTAG_W(RT),
                .WQ_DEPTH(QD), .RQ_DEPTH(QD)) dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- controller model: fixed latency RAM ----------------
  logic [DW-1:0] ram [256];
  logic wr_ack_en = 0, rd_ack_en = 0, rd_ret_model = 1;
  logic man_v = 0;
  logic [DW-1:0] man_d = 0;
  logic [RT-1:0] man_t = 0;
  logic wd_pend_v = 0;
  logic [WT-1:0] wd_pend_t = 0;
  logic s0_v = 0, s1_v = 0;
  logic [DW-1:0] s0_d = 0, s1_d = 0;
  logic [RT-1:0] s0_t = 0, s1_t = 0;

  initial for (int i = 0; i < 256; i++) ram[i] = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mc_wr_ack = 0; mc_rd_ack = 0; mc_wr_done_valid = 0; mc_rd_data_valid = 0;
      wd_pend_v = 0; s0_v = 0; s1_v = 0;
    end else begin
      mc_wr_done_valid = wd_pend_v;
      mc_wr_done_tag   = wd_pend_t;
      wd_pend_v = 0;
      mc_wr_ack = wr_ack_en && mc_wr_req;
      if (mc_wr_ack) begin
        ram[mc_wr_addr] = mc_wr_data;
        wd_pend_v = 1;
        wd_pend_t = mc_wr_tag;
      end
      if (rd_ret_model) begin
        mc_rd_data_valid = s1_v; mc_rd_data = s1_d; mc_rd_data_tag = s1_t;
      end else begin
        mc_rd_data_valid = man_v; mc_rd_data = man_d; mc_rd_data_tag = man_t;
      end
      s1_v = s0_v; s1_d = s0_d; s1_t = s0_t;
      s0_v = 0;
      mc_rd_ack = rd_ack_en && mc_rd_req;
      if (mc_rd_ack) begin
        s0_v = 1; s0_d = ram[mc_rd_addr]; s0_t = mc_rd_tag;
      end
    end
  end

  // ---------------- completion monitor ----------------
  logic [WT-1:0] wd_log [$];
  logic [RT-1:0] rt_log [$];
  logic [DW-1:0] rdat_log [$];

  always @(posedge clk) begin
    #2;
    if (rst_n && wr_done_valid) wd_log.push_back(wr_done_tag);
    if (rst_n && rd_resp_valid) begin
      rt_log.push_back(rd_resp_tag);
      rdat_log.push_back(rd_resp_data);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    summary();
  end

  task automatic reset_state_checks();
    check("R10 wr req", mc_wr_req, 0);
    check("R10 rd req", mc_rd_req, 0);
    check("R10 counts", {mc_wr_count, mc_rd_count}, 0);
    check("R10 aempty", {mc_wr_aempty, mc_rd_aempty}, 0);
    check("R10 ready", {wr_cmd_ready, rd_cmd_ready}, 2'b11);
    check("R10 tags", {wr_next_tag, rd_next_tag}, 0);
    check("R10 valids", {wr_done_valid, rd_resp_valid}, 0);
  endtask

  initial begin
    int acc;
    int cnt;
    repeat (4) step();
    reset_state_checks();
    rst_n = 1;
    step();
    reset_state_checks();

    // ---- fill write queue with controller idle (R1 R2 R4 R5) ----
    for (int i = 0; i < QD + 1; i++) begin
      check("R2 write tag", wr_next_tag, (i < QD) ? i : QD);
      check("R5 write ready", wr_cmd_ready, (i < QD) ? 1 : 0);
      wr_cmd_valid = 1; wr_cmd_addr = AW'(i * 3); wr_cmd_data = DW'(16'hA000 + i);
      step();
      cnt = (i + 1 < QD) ? i + 1 : QD;
      check("R4 write count", mc_wr_count, cnt);
      check("R4 write aempty", mc_wr_aempty, (cnt == 1) ? 1 : 0);
      check("R3 write req", mc_wr_req, 1);
    end
    wr_cmd_valid = 0;
    step();
    check("R5 ignored push keeps tag", wr_next_tag, QD);
    check("R5 ignored push keeps count", mc_wr_count, QD);

    // ---- head holds without acknowledge (R3) ----
    for (int k = 0; k < 3; k++) begin
      check("R3 held head tag", mc_wr_tag, 0);
      check("R3 held head addr", mc_wr_addr, 0);
      check("R3 held head data", mc_wr_data, 16'hA000);
      step();
    end

    // ---- drain with ack every cycle: next command each edge (R1 R3 R4) ----
    wr_ack_en = 1;
    for (int k = 1; k < QD; k++) begin
      step();
      check("R3 next write issued", mc_wr_tag, k);
      check("R1 write order addr", mc_wr_addr, k * 3);
      check("R4 draining count", mc_wr_count, QD - k);
    end
    check("R4 last write aempty", mc_wr_aempty, 1);
    step();
    check("R3 write req drops", mc_wr_req, 0);
    check("R4 write empty count", mc_wr_count, 0);
    repeat (3) step();
    check("R6 done count", wd_log.size(), QD);
    for (int k = 0; k < QD && k < wd_log.size(); k++)
      check("R6 done tag", wd_log[k], k);

    // ---- concurrent write and reads, read-after-write (R1 R8 R9 R5) ----
    rd_ack_en = 1;
    rt_log.delete(); rdat_log.delete();
    for (int i = 0; i < 5; i++) begin
      check("R2 read tag", rd_next_tag, i);
      rd_cmd_valid = 1; rd_cmd_addr = AW'(i * 3);
      if (i == 0) begin
        wr_cmd_valid = 1; wr_cmd_addr = 8'd50; wr_cmd_data = 16'hBEEF;
      end else wr_cmd_valid = 0;
      step();
      if (i == 0) begin
        check("R9 both queues one", {mc_wr_count, mc_rd_count}, {CWD'(1), CWD'(1)});
        check("R9 both aempty", {mc_wr_aempty, mc_rd_aempty}, 2'b11);
      end
    end
    rd_cmd_valid = 0;
    repeat (6) step();
    check("R8 read returns", rt_log.size(), 5);
    for (int i = 0; i < 5 && i < rt_log.size(); i++) begin
      check("R8 read tag", rt_log[i], i);
      check("R1 read data", rdat_log[i], (i < QD) ? 16'hA000 + i : 0);
    end
    check("R6 concurrent write done", (wd_log.size() > QD) ? wd_log[QD] : 4'hF, QD);

    rd_cmd_valid = 1; rd_cmd_addr = 8'd50;
    step();
    rd_cmd_valid = 0;
    repeat (6) step();
    check("R1 read after write", (rdat_log.size() > 5) ? rdat_log[5] : 0, 16'hBEEF);
    check("R8 read tag six", (rt_log.size() > 5) ? rt_log[5] : 0, 5);

    // ---- tag limit: returns withheld (R7 R2) ----
    rd_ret_model = 0;
    repeat (3) step();
    acc = 0;
    rd_cmd_valid = 1; rd_cmd_addr = 8'd1;
    for (int c = 0; c < 400; c++) begin
      if (!rd_cmd_ready) break;
      acc++;
      step();
    end
    check("R7 reads accepted before stall", acc, 256);
    check("R2 read tag wrapped", rd_next_tag, 6);
    repeat (3) step();
    check("R7 still stalled", rd_cmd_ready, 0);
    check("R7 no tag advance while stalled", rd_next_tag, 6);
    rd_cmd_valid = 0;
    repeat (3) step();

    // ---- out-of-order returns pass through unchanged (R8 R7) ----
    rt_log.delete(); rdat_log.delete();
    man_v = 1; man_t = 8'd7; man_d = 16'h1111; step();
    man_t = 8'd2; man_d = 16'h2222; step();
    man_t = 8'd5; man_d = 16'h3333; step();
    man_v = 0;
    repeat (3) step();
    check("R8 ooo count", rt_log.size(), 3);
    if (rt_log.size() == 3) begin
      check("R8 ooo tag first", rt_log[0], 7);
      check("R8 ooo tag second", rt_log[1], 2);
      check("R8 ooo tag third", rt_log[2], 5);
      check("R8 ooo data third", rdat_log[2], 16'h3333);
    end
    check("R7 room after returns", rd_cmd_ready, 1);

    summary();
  end

endmodule